// File: doc/BRIEF.md
# Segment:Offset Memory Read Master

This block turns a read request given as a 16-bit segment and a 16-bit offset into a 20-bit linear address. The segment is shifted left by four bit positions and the offset is added to it. The block then runs one read on a simple strobed memory bus. The bus has an address output, an active-low read strobe and an input data bus. Each read takes a fixed four-cycle sequence:

1. The address is presented.
2. The strobe falls.
3. The strobe stays low for one wait cycle while the memory responds.
4. The strobe returns high with the data valid on the bus, and the data is captured at the end of that cycle.

A requester pulses `start` with the segment and offset. It watches `busy` for the active window and receives the captured byte on `rdata`, together with a one-cycle `done` pulse.

Top module: `seg_read_master`

## Requirements
- R1: `bus_addr` is `seg` * 16 + `ofs` taken over 20 bits. For example, 08F1h:0100h gives 09010h, 028Fh:0030h gives 02920h, and both 28F0h:0030h and 28B0h:0430h give 28F30h.
- R2: The sum wraps modulo 2^20. FFFFh:0010h gives 00000h, and FFFFh:FFFFh gives 0FFEFh.
- R3: Let E0 be the clock edge that samples `start` high while the block is idle. From E0, `bus_addr` carries the new address, and it stays unchanged through the whole read.
- R4: `bus_rd_n` is low in exactly the second and third cycles after E0. It is high in the first and fourth cycles.
- R5: At the fourth edge after E0, `rdata` loads `bus_data` as it stands in the fourth cycle, the one where `bus_rd_n` is high again. `done` is high for exactly the one cycle after that edge.
- R6: `busy` is high for exactly the four cycles of the read and low in the cycle where `done` is high.
- R7: A `start` pulse sampled while `busy` is high is ignored. The address, the timing and the result of the read in flight do not change, and no second read follows.
- R8: Between reads, `bus_rd_n` stays high, and both `bus_addr` and `rdata` hold their last values.
- R9: While `rst_n` is low, the block is forced idle at once, even in the middle of a read. In that state `bus_rd_n` is 1, `busy` and `done` are 0, and `bus_addr` and `rdata` are 0. Release takes effect two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Read request pulse |
| seg | input | 16 | Segment value |
| ofs | input | 16 | Offset value |
| bus_addr | output | 20 | Linear address bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_data | input | 8 | Memory data bus |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Read in progress |

## Verification
The hardest case to reach is the capture instant. A design that samples the data one cycle early or one cycle late would still return a plausible byte from a memory that always drives good data. To expose this, the bench memory drives the true byte only in the cycle after the strobe has been low, and drives its complement in every other cycle. Only a capture in the correct cycle therefore matches. Ignored requests are also hard to reach, because they must land inside the four-cycle window. The bench places extra start pulses on the first strobe-low cycle and on the final cycle, each carrying a different segment.

// File: rtl/seg_rd_pkg.sv
package seg_rd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_STROBE = 3'd2,
    PH_WAIT   = 3'd3,
    PH_DATA   = 3'd4
  } phase_t;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/seg_lin_addr.sv
module seg_lin_addr #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] lin
);
  localparam int SUM_W = SEG_W + SHIFT + 1;

  logic [SUM_W-1:0] seg_sh;
  logic [SUM_W-1:0] ofs_ext;
  logic [SUM_W-1:0] sum;

  always_comb begin
    seg_sh  = {1'b0, seg, {SHIFT{1'b0}}};
    ofs_ext = SUM_W'(ofs);
    sum     = seg_sh + ofs_ext;
    lin     = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/seg_rd_seq.sv
module seg_rd_seq
  import seg_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic cap_en,
  output logic rd_n,
  output logic busy,
  output logic done
);
  phase_t ph_q, ph_d;
  logic   rd_n_q, rd_n_d;
  logic   done_q, done_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (start) ph_d = PH_ADDR;
      PH_ADDR:   ph_d = PH_STROBE;
      PH_STROBE: ph_d = PH_WAIT;
      PH_WAIT:   ph_d = PH_DATA;
      PH_DATA:   ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
    rd_n_d  = !((ph_d == PH_STROBE) || (ph_d == PH_WAIT));
    done_d  = (ph_q == PH_DATA);
    load_en = (ph_q == PH_IDLE) && start;
    cap_en  = (ph_q == PH_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      rd_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rd_n_q <= rd_n_d;
      done_q <= done_d;
    end
  end

  assign rd_n = rd_n_q;
  assign busy = (ph_q != PH_IDLE);
  assign done = done_q;
endmodule

// File: rtl/seg_read_master.sv
module seg_read_master #(
  parameter int SEG_W    = 16,
  parameter int OFS_W    = 16,
  parameter int SHIFT    = 4,
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy
);
  logic              rst_n_s;
  logic              load_en;
  logic              cap_en;
  logic [ADDR_W-1:0] lin;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  seg_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  seg_lin_addr #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
  ) u_lin (
    .seg(seg), .ofs(ofs), .lin(lin)
  );

  seg_rd_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .load_en(load_en), .cap_en(cap_en),
    .rd_n(bus_rd_n), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     addr_q <= '0;
    else if (load_en) addr_q <= lin;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    data_q <= '0;
    else if (cap_en) data_q <= bus_data;
  end

  assign bus_addr = addr_q;
  assign rdata    = data_q;
endmodule

// File: rtl/seg_read_master_chk.sv
module seg_read_master_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd_n,
  input logic              done,
  input logic              busy
);
  AST_STROBE_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |=> !bus_rd_n); // R4
  AST_STROBE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && $past(!bus_rd_n)) |=> bus_rd_n); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy)); // R6
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr)); // R3
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(bus_addr)); // R7
  AST_IDLE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_rd_n); // R8
  AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || $stable(bus_addr))); // R8
endmodule

bind seg_read_master seg_read_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_addr(bus_addr),
  .bus_rd_n(bus_rd_n), .done(done), .busy(busy)
);

// File: tb/sim_seg_read_master.sv
`timescale 1ns/1ps
module sim_seg_read_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] seg;
  logic [15:0] ofs;
  logic [19:0] bus_addr;
  logic        bus_rd_n;
  logic [7:0]  bus_data;
  logic [7:0]  rdata;
  logic        done;
  logic        busy;
  logic        prev_rd_n;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  seg_read_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seg(seg), .ofs(ofs),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_data(bus_data),
    .rdata(rdata), .done(done), .busy(busy)
  );

  function automatic logic [7:0] mem_f(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'hA};
  endfunction

  // memory: true byte only in the cycle after the strobe was low, complement otherwise
  always @(posedge clk) prev_rd_n <= bus_rd_n;
  assign bus_data = (bus_rd_n && !prev_rd_n) ? mem_f(bus_addr) : ~mem_f(bus_addr);

  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {16'h08F1, 16'h0100, 20'h09010},
    {16'h028F, 16'h0030, 20'h02920},
    {16'h28F0, 16'h0030, 20'h28F30},
    {16'h28B0, 16'h0430, 20'h28F30},
    {16'h1234, 16'h5678, 20'h179B8},
    {16'h0000, 16'h0000, 20'h00000},
    {16'hFFFF, 16'h0010, 20'h00000},
    {16'hFFFF, 16'hFFFF, 20'h0FFEF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] s, input logic [15:0] o,
                         input logic [19:0] ea, input int ign, input string rq);
    logic [7:0] ed;
    ed = mem_f(ea);
    @(negedge clk); start = 1'b1; seg = s; ofs = o;
    @(negedge clk); start = 1'b0; seg = 16'hAAAA; ofs = 16'h5555;
    chk(bus_addr == ea, rq, 32'(bus_addr), 32'(ea));                     // R1 R3
    chk(busy && bus_rd_n, "R4 cycle1", {busy, bus_rd_n}, 2'b11);
    @(negedge clk);
    chk(busy && !bus_rd_n, "R4 cycle2", {busy, bus_rd_n}, 2'b10);
    if (ign == 2) start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!bus_rd_n && bus_addr == ea, "R4 cycle3", {bus_rd_n, bus_addr}, {1'b0, ea});
    @(negedge clk);
    chk(busy && bus_rd_n && !done, "R6 cycle4", {busy, bus_rd_n, done}, 3'b110);
    if (ign == 4) start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && !busy, "R5 R6 done", {done, busy}, 2'b10);
    chk(rdata == ed, "R5 rdata", 32'(rdata), 32'(ed));
    chk(bus_addr == ea, "R7 addr", 32'(bus_addr), 32'(ea));
    @(negedge clk);
    chk(!done && !busy && bus_rd_n, "R7 R8 idle", {done, busy, bus_rd_n}, 3'b001);
    repeat (3) @(negedge clk);
    chk(bus_addr == ea && rdata == ed && bus_rd_n, "R8 hold",
        {bus_rd_n, rdata, bus_addr}, {1'b1, ed, ea});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; seg = '0; ofs = '0;
    repeat (3) @(negedge clk);
    chk(bus_rd_n && !busy && !done && bus_addr == 0 && rdata == 0, "R9 reset",
        {bus_rd_n, busy, done, rdata, bus_addr}, {3'b100, 8'h00, 20'h0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++)
      do_read(VEC[i][51:36], VEC[i][35:20], VEC[i][19:0], 0,
              (i >= 6) ? "R2 wrap addr" : "R1 addr");

    do_read(16'h0100, 16'h0023, 20'h01023, 2, "R7 ignore in strobe");
    do_read(16'h0ABC, 16'h0004, 20'h0ABC4, 4, "R7 ignore in last cycle");

    // reset in the middle of a read
    @(negedge clk); start = 1'b1; seg = 16'h4000; ofs = 16'h0007;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(!bus_rd_n, "R9 setup strobe", 32'(bus_rd_n), 0);
    #1 rst_n = 1'b0;
    #1 chk(bus_rd_n && !busy && bus_addr == 0 && rdata == 0, "R9 async",
           {bus_rd_n, busy, rdata, bus_addr}, {2'b10, 8'h00, 20'h0});
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && !busy && bus_rd_n, "R9 after release", {done, busy, bus_rd_n}, 3'b001);
    do_read(16'h08F1, 16'h0100, 20'h09010, 0, "R9 R1 after reset");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule